// File: doc/BRIEF.md
# Counter-Mode Packet Keystream Sequencer

This block drives counter-mode encryption and decryption of fixed-size radio packets. Every cipher input block is built from a session prefix in the upper bytes and a running block counter in the low bytes. The block requests one keystream block at a time from an external block cipher over a request/response handshake. It then XORs that keystream byte by byte with the payload as the payload streams through.

In transmit mode a packet begins with the starting counter value as a header, most significant byte first. Seven payload blocks follow, encrypted with counter values n to n+6, and the local counter then moves on by seven. In receive mode the first header bytes of the incoming packet supply the starting counter. The same XOR recovers the plaintext, and no local state changes. A receiver can therefore discard a corrupted packet upstream without losing synchronisation.

A counter value must never be used twice under one key. The block raises an exhausted flag and refuses new transmit packets once fewer counter values remain than one packet needs. Loading a new prefix restarts the counter at zero and clears the flag.

Top module: `ctr_seq`

## Requirements
- R1: The cipher request block is the prefix in its upper 128−CNT_W bits and the counter in its low CNT_W bits. Payload byte k of a block (k = 0 first) is XORed with bits [127−8k −: 8] of the cipher response.
- R2: A prefix load (pfx_valid high for one cycle) sets the transmit counter to 0 and clears exhausted. The next transmit header carries 0.
- R3: Each payload block uses its own counter value, one higher than the previous block. Consecutive transmit packets start at n and n+7.
- R4: A transmit packet outputs CNT_W/8 header bytes holding the starting counter, most significant byte first. It then outputs 112 ciphertext bytes from 7 blocks using counters n to n+6.
- R5: A receive packet (rx_mode high at packet start) takes its first CNT_W/8 input bytes, most significant first, as the starting counter and does not output them. It then outputs 112 bytes XORed with the keystream for n to n+6.
- R6: A receive packet leaves the transmit counter unchanged.
- R7: exhausted is high exactly when the transmit counter exceeds 2^CNT_W − 7. While it is high, a transmit packet is refused: in_ready, out_valid and ks_req_valid stay low.
- R8: Receive packets are still accepted and processed while exhausted is high.
- R9: At most one keystream request is pending at a time. The request block is held stable until ks_req_ready. No payload byte is accepted while a request is pending.
- R10: Output bytes follow valid/ready. No byte is lost or repeated under backpressure, and out_data is held while stalled.
- R11: After reset, out_valid, in_ready, ks_req_valid and exhausted are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pfx_valid | input | 1 | Load a new session prefix |
| pfx_data | input | 128−CNT_W (96) | Session prefix value |
| rx_mode | input | 1 | 1 = decrypt packet with header input, 0 = encrypt packet |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte (header or payload) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Header or XORed payload byte |
| ks_req_valid | output | 1 | Keystream request pending |
| ks_req_ready | input | 1 | Cipher accepts the request |
| ks_req_block | output | 128 | Counter block to encrypt |
| ks_rsp_valid | input | 1 | Keystream block returned |
| ks_rsp_data | input | 128 | Keystream block |
| exhausted | output | 1 | Too few counter values left for a transmit packet |

## Verification
The hardest state to reach is counter exhaustion. With a 32-bit counter it would take hundreds of millions of packets. The bench therefore builds the block with an 8-bit counter (one header byte, 120-bit prefix). It sends 36 transmit packets to land on the boundary: not exhausted after 35, exhausted after 36. It then checks that a waiting transmit packet is refused, a receive packet still passes, and a prefix reload recovers. A cipher model with varying latency and ready gaps, plus output backpressure, exercises the handshakes alongside this.

// File: rtl/ctr_seq_pkg.sv
package ctr_seq_pkg;
    localparam int BYTE_W      = 8;
    localparam int BLOCK_BYTES = 16;
    localparam int BLOCK_W     = BLOCK_BYTES * BYTE_W;
    localparam int BYTE_IDX_W  = $clog2(BLOCK_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_OUT,
        ST_HDR_IN,
        ST_REQ,
        ST_WAIT,
        ST_DATA
    } seq_state_e;

    // byte 0 is the most significant byte of the block
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [BLOCK_W-1:0] blk,
                                                    input logic [BYTE_IDX_W-1:0] idx);
        logic [BLOCK_W-1:0] t;
        t = blk >> (BYTE_W * (BLOCK_BYTES - 1 - int'(idx)));
        return t[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/ctr_session.sv
module ctr_session
    import ctr_seq_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int BLKS_PER_PKT = 7,
    localparam int PREFIX_W    = BLOCK_W - CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [PREFIX_W-1:0] pfx_in,
    input  logic                step,
    output logic [PREFIX_W-1:0] prefix,
    output logic [CNT_W-1:0]    tx_cnt,
    output logic                exhausted
);
    localparam logic [CNT_W-1:0] LAST_START = {CNT_W{1'b1}} - CNT_W'(BLKS_PER_PKT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prefix <= '0;
            tx_cnt <= '0;
        end else if (load) begin
            prefix <= pfx_in;
            tx_cnt <= '0;
        end else if (step) begin
            tx_cnt <= tx_cnt + 1'b1;
        end
    end

    assign exhausted = (tx_cnt > LAST_START);
endmodule

// File: rtl/ctr_ks_port.sv
module ctr_ks_port
    import ctr_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap,
    input  logic [BLOCK_W-1:0]    rsp_data,
    input  logic [BYTE_IDX_W-1:0] idx,
    output logic [BYTE_W-1:0]     ks_byte
);
    logic [BLOCK_W-1:0] ks_q;

    always_ff @(posedge clk) begin
        if (rst)      ks_q <= '0;
        else if (cap) ks_q <= rsp_data;
    end

    assign ks_byte = pick_byte(ks_q, idx);
endmodule

// File: rtl/ctr_seq.sv
module ctr_seq
    import ctr_seq_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int BLKS_PER_PKT = 7,
    localparam int PREFIX_W    = BLOCK_W - CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pfx_valid,
    input  logic [PREFIX_W-1:0] pfx_data,
    input  logic                rx_mode,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [BYTE_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BYTE_W-1:0]   out_data,
    output logic                ks_req_valid,
    input  logic                ks_req_ready,
    output logic [BLOCK_W-1:0]  ks_req_block,
    input  logic                ks_rsp_valid,
    input  logic [BLOCK_W-1:0]  ks_rsp_data,
    output logic                exhausted
);
    localparam int HDR_BYTES = CNT_W / BYTE_W;
    localparam int HB_W      = $clog2(HDR_BYTES + 1);
    localparam int BK_W      = $clog2(BLKS_PER_PKT + 1);

    seq_state_e            state;
    logic                  pkt_rx;
    logic [CNT_W-1:0]      blk_cnt;
    logic [CNT_W-1:0]      hdr_q;
    logic [CNT_W-1:0]      hdr_next;
    logic [HB_W-1:0]       hb;
    logic [BYTE_IDX_W-1:0] bi;
    logic [BK_W-1:0]       blk_i;
    logic [PREFIX_W-1:0]   prefix;
    logic [CNT_W-1:0]      tx_cnt;
    logic                  step;
    logic                  cap;
    logic [BYTE_W-1:0]     ks_byte;

    assign step = (state == ST_REQ) && ks_req_ready && !pkt_rx;
    assign cap  = (state == ST_WAIT) && ks_rsp_valid;

    ctr_session #(.CNT_W(CNT_W), .BLKS_PER_PKT(BLKS_PER_PKT)) u_session (
        .clk       (clk),
        .rst       (rst),
        .load      (pfx_valid),
        .pfx_in    (pfx_data),
        .step      (step),
        .prefix    (prefix),
        .tx_cnt    (tx_cnt),
        .exhausted (exhausted)
    );

    ctr_ks_port u_ks (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .rsp_data (ks_rsp_data),
        .idx      (bi),
        .ks_byte  (ks_byte)
    );

    assign hdr_next     = (hdr_q << BYTE_W) | CNT_W'(in_data);
    assign ks_req_valid = (state == ST_REQ);
    assign ks_req_block = {prefix, blk_cnt};
    assign in_ready     = (state == ST_HDR_IN) || ((state == ST_DATA) && out_ready);
    assign out_valid    = (state == ST_HDR_OUT) || ((state == ST_DATA) && in_valid);
    assign out_data     = (state == ST_HDR_OUT) ? hdr_q[CNT_W-1 -: BYTE_W]
                                                : (in_data ^ ks_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pkt_rx  <= 1'b0;
            blk_cnt <= '0;
            hdr_q   <= '0;
            hb      <= '0;
            bi      <= '0;
            blk_i   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    hb    <= '0;
                    blk_i <= '0;
                    if (in_valid) begin
                        if (rx_mode) begin
                            pkt_rx <= 1'b1;
                            hdr_q  <= '0;
                            state  <= ST_HDR_IN;
                        end else if (!exhausted) begin
                            pkt_rx  <= 1'b0;
                            hdr_q   <= tx_cnt;
                            blk_cnt <= tx_cnt;
                            state   <= ST_HDR_OUT;
                        end
                    end
                end
                ST_HDR_OUT: begin
                    if (out_ready) begin
                        hdr_q <= hdr_q << BYTE_W;
                        hb    <= hb + 1'b1;
                        if (hb == HB_W'(HDR_BYTES - 1)) state <= ST_REQ;
                    end
                end
                ST_HDR_IN: begin
                    if (in_valid) begin
                        hdr_q <= hdr_next;
                        hb    <= hb + 1'b1;
                        if (hb == HB_W'(HDR_BYTES - 1)) begin
                            blk_cnt <= hdr_next;
                            state   <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (ks_req_ready) begin
                        blk_cnt <= blk_cnt + 1'b1;
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (ks_rsp_valid) begin
                        bi    <= '0;
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (in_valid && out_ready) begin
                        bi <= bi + 1'b1;
                        if (bi == BYTE_IDX_W'(BLOCK_BYTES - 1)) begin
                            if (blk_i == BK_W'(BLKS_PER_PKT - 1)) begin
                                state <= ST_IDLE;
                            end else begin
                                blk_i <= blk_i + 1'b1;
                                state <= ST_REQ;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctr_seq_chk.sv
module ctr_seq_chk #(
    parameter int CNT_W        = 32,
    parameter int BLKS_PER_PKT = 7
) (
    input logic         clk,
    input logic         rst,
    input logic         pfx_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [7:0]   out_data,
    input logic         ks_req_valid,
    input logic         ks_req_ready,
    input logic [127:0] ks_req_block,
    input logic         exhausted
);
    localparam int NA_W = $clog2(BLKS_PER_PKT + 1);

    logic             fire;
    logic [NA_W-1:0]  n_acc;
    logic [CNT_W-1:0] last_lo;

    assign fire = ks_req_valid && ks_req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_acc   <= '0;
            last_lo <= '0;
        end else if (fire) begin
            last_lo <= ks_req_block[CNT_W-1:0];
            n_acc   <= (n_acc == NA_W'(BLKS_PER_PKT - 1)) ? '0 : n_acc + 1'b1;
        end
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && n_acc != '0) |-> (ks_req_block[CNT_W-1:0] == CNT_W'(last_lo + 1'b1)));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ks_req_valid && !ks_req_ready) |=> (ks_req_valid && $stable(ks_req_block)));

    assert_no_pass_R9: assert property (@(posedge clk) disable iff (rst)
        ks_req_valid |-> (!in_ready && !out_valid));

    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_load_clear_R2: assert property (@(posedge clk) disable iff (rst)
        pfx_valid |=> !exhausted);
endmodule

bind ctr_seq ctr_seq_chk #(.CNT_W(CNT_W), .BLKS_PER_PKT(BLKS_PER_PKT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pfx_valid    (pfx_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .ks_req_valid (ks_req_valid),
    .ks_req_ready (ks_req_ready),
    .ks_req_block (ks_req_block),
    .exhausted    (exhausted)
);

// File: tb/ctr_seq_tb.sv
`timescale 1ns/1ps
module ctr_seq_tb;
    localparam int CW = 8;
    localparam int PW = 128 - CW;
    localparam int HB = CW / 8;
    localparam int NB = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pfx_valid = 1'b0;
    logic [PW-1:0] pfx_data = '0;
    logic          rx_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [7:0]    out_data;
    logic          ks_req_valid;
    logic          ks_req_ready = 1'b1;
    logic [127:0]  ks_req_block;
    logic          ks_rsp_valid = 1'b0;
    logic [127:0]  ks_rsp_data = '0;
    logic          exhausted;

    ctr_seq #(.CNT_W(CW), .BLKS_PER_PKT(NB)) u_dut (
        .clk(clk), .rst(rst), .pfx_valid(pfx_valid), .pfx_data(pfx_data),
        .rx_mode(rx_mode), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .ks_req_valid(ks_req_valid), .ks_req_ready(ks_req_ready),
        .ks_req_block(ks_req_block), .ks_rsp_valid(ks_rsp_valid),
        .ks_rsp_data(ks_rsp_data), .exhausted(exhausted)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [PW-1:0] m_pfx = '0;
    logic [CW-1:0] m_cnt = '0;
    logic [7:0]    exp_q[$];
    string         tag_q[$];
    logic [127:0]  req_q[$];

    function automatic logic [127:0] cipher(input logic [127:0] b);
        return {b[86:0], b[127:87]} ^ 128'hC3A5_5A3C_0F1E_2D4B_9687_7869_E1D2_F0B4;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // cipher model with varying latency, checks every request block (R1, R3)
    initial begin : cipher_model
        int lat_ctr = 0;
        forever begin
            @(negedge clk);
            if (!rst && ks_req_valid && ks_req_ready) begin
                logic [127:0] cb;
                cb = ks_req_block;
                if (req_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected request", cb, '0);
                end else begin
                    logic [127:0] e;
                    e = req_q.pop_front();
                    check(cb == e, "R3", "request block", cb, e);
                end
                lat_ctr++;
                @(posedge clk);
                repeat (lat_ctr % 3) @(posedge clk);
                #1;
                ks_rsp_valid = 1'b1;
                ks_rsp_data  = cipher(cb);
                @(posedge clk);
                #1;
                ks_rsp_valid = 1'b0;
                ks_rsp_data  = '0;
            end
        end
    end

    // ready patterns for cipher and downstream
    initial begin : ready_gen
        int c = 0;
        forever begin
            @(posedge clk);
            #1;
            c++;
            ks_req_ready = (c % 4) != 1;
            out_ready    = (c % 5) != 3;
        end
    end

    // monitor / scoreboard (R10)
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected output byte", 128'(out_data), '0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_data == e, t, "output byte", 128'(out_data), 128'(e));
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", '0, '0);
        finish_run();
    end

    task automatic drive_byte(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic load_prefix(input logic [PW-1:0] p);
        @(posedge clk);
        #1;
        pfx_valid = 1'b1;
        pfx_data  = p;
        @(posedge clk);
        #1;
        pfx_valid = 1'b0;
        m_pfx = p;
        m_cnt = '0;
    endtask

    task automatic tx_pkt(input int seed, input string hdr_tag);
        logic [7:0]   pay[NB*16];
        logic [CW-1:0] n;
        n = m_cnt;
        for (int h = 0; h < HB; h++) begin
            exp_q.push_back(8'(n >> (8 * (HB - 1 - h))));
            tag_q.push_back(hdr_tag);
        end
        for (int b = 0; b < NB; b++) begin
            logic [127:0] cb;
            logic [127:0] ks;
            cb = {m_pfx, CW'(n + CW'(b))};
            ks = cipher(cb);
            req_q.push_back(cb);
            for (int k = 0; k < 16; k++) begin
                pay[b*16+k] = 8'(seed * 37 + b * 16 + k * 5);
                exp_q.push_back(pay[b*16+k] ^ 8'(ks >> (8 * (15 - k))));
                tag_q.push_back("R1");
            end
        end
        m_cnt = n + CW'(NB);
        rx_mode = 1'b0;
        for (int i = 0; i < NB*16; i++) drive_byte(pay[i]);
    endtask

    task automatic rx_pkt(input logic [CW-1:0] n, input int seed, input string tag);
        logic [7:0] ct[NB*16];
        for (int b = 0; b < NB; b++) begin
            logic [127:0] cb;
            logic [127:0] ks;
            cb = {m_pfx, CW'(n + CW'(b))};
            ks = cipher(cb);
            req_q.push_back(cb);
            for (int k = 0; k < 16; k++) begin
                ct[b*16+k] = 8'(seed * 11 + b * 7 + k * 13);
                exp_q.push_back(ct[b*16+k] ^ 8'(ks >> (8 * (15 - k))));
                tag_q.push_back(tag);
            end
        end
        rx_mode = 1'b1;
        for (int h = 0; h < HB; h++) drive_byte(8'(n >> (8 * (HB - 1 - h))));
        for (int i = 0; i < NB*16; i++) drive_byte(ct[i]);
    endtask

    task automatic wait_drain(input string req);
        int t = 0;
        while ((exp_q.size() != 0 || req_q.size() != 0) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        check(exp_q.size() == 0 && req_q.size() == 0, req, "all bytes delivered",
              128'(exp_q.size()), '0);
    endtask

    initial begin : main
        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!out_valid, "R11", "out_valid after reset", 128'(out_valid), '0);
        check(!in_ready, "R11", "in_ready after reset", 128'(in_ready), '0);
        check(!ks_req_valid, "R11", "ks_req_valid after reset", 128'(ks_req_valid), '0);
        check(!exhausted, "R11", "exhausted after reset", 128'(exhausted), '0);

        load_prefix(120'h0102_0304_0506_0708_090A_0B0C_0D0E_0F);
        tx_pkt(1, "R4");          // header 0
        tx_pkt(2, "R3");          // header 7
        wait_drain("R4");

        rx_pkt(8'h30, 3, "R5");   // decrypt with counters 0x30..0x36
        wait_drain("R5");
        tx_pkt(4, "R6");          // header still 14
        wait_drain("R6");

        load_prefix(120'hA0A1_A2A3_A4A5_A6A7_A8A9_AAAB_ACAD_AE);
        @(negedge clk);
        check(!exhausted, "R2", "exhausted after load", 128'(exhausted), '0);
        tx_pkt(5, "R2");          // header 0 after reload
        for (int p = 0; p < 34; p++) tx_pkt(20 + p, "R3");
        wait_drain("R3");
        check(!exhausted, "R7", "exhausted at counter 245", 128'(exhausted), '0);
        tx_pkt(60, "R7");         // last permitted packet, start 245
        wait_drain("R7");
        check(exhausted, "R7", "exhausted at counter 252", 128'(exhausted), 128'(1));

        // R7 refused transmit packet
        @(posedge clk);
        #1;
        rx_mode  = 1'b0;
        in_data  = 8'h55;
        in_valid = 1'b1;
        begin
            bit quiet;
            quiet = 1'b1;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (in_ready || out_valid || ks_req_valid) quiet = 1'b0;
            end
            check(quiet, "R7", "transmit refused while exhausted",
                  128'({in_ready, out_valid, ks_req_valid}), '0);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;

        rx_pkt(8'h10, 9, "R8");   // receive still works
        wait_drain("R8");
        check(exhausted, "R8", "exhausted kept after receive", 128'(exhausted), 128'(1));

        load_prefix(120'h5555_6666_7777_8888_9999_AAAA_BBBB_CC);
        @(negedge clk);
        check(!exhausted, "R2", "exhausted cleared by reload", 128'(exhausted), '0);
        tx_pkt(10, "R2");
        wait_drain("R2");

        finish_run();
    end
endmodule